// File: doc/BRIEF.md
# Nine-Bit Serial Command Transmitter

This block is a write-only serial master for the control port of a display module. A requester hands over a register code, a length code and a 16-bit payload. The block turns them into one chip-select frame of one, two or three 9-bit words. The first word of a frame always holds the register or command code. Any words after it hold data. The top bit of each word tells the panel whether the word is a command or data. There is no input data line, so nothing is ever read back.

The serial clock idles high. Data is launched on the falling edge and sampled by the panel on the rising edge. Each half period lasts `CLK_DIV/2` system clocks. Requests use a valid/ready handshake. A single-cycle `done` pulse marks the end of every frame.

Top module: `ninebit_cmd_tx`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 1, `req_ready` is 1 and `done` is 0.
- R2: Every word is 9 bits and is sent most significant bit first. Bit 8 is 0 for the command word and 1 for each data word. Bits 7..0 hold the byte.
- R3: Length code 0 sends a single command word, `{0, req_reg}`.
- R4: Length code 1 sends the command word, then one data word `{1, req_data[7:0]}`.
- R5: Length code 2 sends the command word, then `{1, req_data[15:8]}`, then `{1, req_data[7:0]}`.
- R6: Length code 3 is reserved and sends a single command word, the same as code 0.
- R7: `sclk` is high whenever `cs_n` is high. Within a frame, the low phase and the high phase each last `CLK_DIV/2` clocks, and so does the lead phase after `cs_n` falls. `sdo` changes only together with a falling `sclk`, so it is stable across every rising edge.
- R8: A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. `cs_n` then falls on the next cycle and stays low through the last bit. Between two frames, `cs_n` stays high for at least `CLK_DIV` clocks.
- R9: `req_ready` is 0 from acceptance until the block is idle again. Fields are captured at acceptance. A request made while `req_ready` is 0 is not taken, and field changes made after acceptance do not alter the frame.
- R10: `done` is high for exactly one clock: the clock in which `cs_n` returns high after a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_reg | input | 8 | Register or command code |
| req_len | input | 2 | 0 command only, 1 byte, 2 half-word, 3 reserved |
| req_data | input | 16 | Payload |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bound checker watches the cycle-level rules on every clock. These are: the idle-high clock, `sdo` moving only with a falling `sclk`, `req_ready` staying low under an active chip select, the start of a frame after acceptance, and the single-cycle `done` pulse at the chip-select rising edge. The bit content of each frame can only be shown by the bench's scenarios. This covers the command/data flag, the byte order of half-word writes, the reserved length code and the capture of fields at acceptance. The same holds for the exact half-period lengths and the gap between back-to-back frames.

// File: rtl/ninebit_tx_pkg.sv
package ninebit_tx_pkg;

  localparam int WORD_W    = 9;
  localparam int MAX_WORDS = 3;
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int BITS_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    LEN_CMD  = 2'd0,
    LEN_BYTE = 2'd1,
    LEN_HALF = 2'd2,
    LEN_RSVD = 2'd3
  } len_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP_A,
    ST_GAP_B
  } seq_e;

  // Number of serial bits a length code produces (reserved acts as command only).
  function automatic logic [BITS_W-1:0] frame_bits(input logic [1:0] len);
    case (len)
      LEN_BYTE: frame_bits = BITS_W'(2 * WORD_W);
      LEN_HALF: frame_bits = BITS_W'(3 * WORD_W);
      default:  frame_bits = BITS_W'(WORD_W);
    endcase
  endfunction

  // Frame image, left aligned: the first bit to send is bit FRAME_W-1.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [7:0]  code,
                                                    input logic [1:0]  len,
                                                    input logic [15:0] data);
    case (len)
      LEN_BYTE: pack_frame = {1'b0, code, 1'b1, data[7:0], 9'd0};
      LEN_HALF: pack_frame = {1'b0, code, 1'b1, data[15:8], 1'b1, data[7:0]};
      default:  pack_frame = {1'b0, code, 18'd0};
    endcase
  endfunction

endpackage

// File: rtl/nbtx_phase_timer.sv
module nbtx_phase_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (phase_end) cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/nbtx_shifter.sv
module nbtx_shifter #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh;

  assign msb = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_val;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end
endmodule

// File: rtl/nbtx_seq.sv
module nbtx_seq
  import ninebit_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BITS_W-1:0] bits_total,
  input  logic              phase_end,
  output seq_e              state,
  output logic              shift,
  output logic              last_edge,
  output logic              done_q
);
  logic [BITS_W-1:0] bits_left;

  assign shift     = (state == ST_HIGH) && phase_end;
  assign last_edge = shift && (bits_left == BITS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last_edge;
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_LEAD;
          bits_left <= bits_total;
        end
        ST_LEAD:  if (phase_end) state <= ST_LOW;
        ST_LOW:   if (phase_end) state <= ST_HIGH;
        ST_HIGH:  if (phase_end) begin
          if (last_edge) state <= ST_GAP_A;
          else begin
            state     <= ST_LOW;
            bits_left <= bits_left - BITS_W'(1);
          end
        end
        ST_GAP_A: if (phase_end) state <= ST_GAP_B;
        ST_GAP_B: if (phase_end) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ninebit_cmd_tx.sv
module ninebit_cmd_tx
  import ninebit_tx_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_reg,
  input  logic [1:0]  req_len,
  input  logic [15:0] req_data,
  output logic        sclk,
  output logic        sdo,
  output logic        cs_n,
  output logic        done
);
  localparam int HALF = CLK_DIV / 2;

  seq_e state;
  logic accept;
  logic phase_end;
  logic run;
  logic shift_evt;
  logic last_edge;
  logic frame_live;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign run        = (state != ST_IDLE);
  assign frame_live = (state == ST_LEAD) || (state == ST_LOW) || (state == ST_HIGH);

  nbtx_phase_timer #(.HALF(HALF)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .phase_end (phase_end)
  );

  nbtx_shifter #(.W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (pack_frame(req_reg, req_len, req_data)),
    .shift    (shift_evt),
    .msb      (sdo)
  );

  nbtx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .bits_total (frame_bits(req_len)),
    .phase_end  (phase_end),
    .state      (state),
    .shift      (shift_evt),
    .last_edge  (last_edge),
    .done_q     (done)
  );

  assign cs_n = !frame_live;
  assign sclk = (state != ST_LOW);
endmodule

// File: rtl/nbtx_checker.sv
module nbtx_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic sclk,
  input logic sdo,
  input logic cs_n,
  input logic done,
  input logic shift_evt
);
  // R9: no new request can be taken while chip select is active
  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R8: acceptance opens a frame on the next clock
  p_accept_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n);

  // R7: clock idles high outside a frame
  p_idle_clock_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R7: inside a frame the data line moves only with a falling clock
  p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(sdo)) |-> $fell(sclk));

  // R2: a shift step leads into a low clock phase or out of the frame
  p_shift_to_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (!sclk || cs_n));

  // R10: done is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done matches the chip select rising edge
  p_done_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);
  p_rise_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
endmodule

bind ninebit_cmd_tx nbtx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .sclk      (sclk),
  .sdo       (sdo),
  .cs_n      (cs_n),
  .done      (done),
  .shift_evt (shift_evt)
);

// File: tb/ninebit_cmd_tx_tb_top.sv
`timescale 1ns/1ps
module ninebit_cmd_tx_tb_top;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_reg = '0;
  logic [1:0] req_len = '0;
  logic [15:0] req_data = '0;
  logic req_ready, sclk, sdo, cs_n, done;

  always #2 clk = ~clk;

  ninebit_cmd_tx #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reg(req_reg), .req_len(req_len), .req_data(req_data),
    .sclk(sclk), .sdo(sdo), .cs_n(cs_n), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [26:0] exp_val[$];
  int          exp_len[$];
  int          frames_seen = 0;
  bit          mon_on = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected frame, built word by word from the requirements (R2..R6).
  task automatic expect_frame(input logic [7:0] code, input logic [1:0] len, input logic [15:0] data);
    logic [8:0] words[$];
    logic [26:0] v = '0;
    words.push_back({1'b0, code});
    if (len == 2'd1) words.push_back({1'b1, data[7:0]});
    if (len == 2'd2) begin
      words.push_back({1'b1, data[15:8]});
      words.push_back({1'b1, data[7:0]});
    end
    foreach (words[i]) v = (v << 9) | 27'(words[i]);
    exp_val.push_back(v);
    exp_len.push_back(9 * words.size());
  endtask

  task automatic send(input logic [7:0] code, input logic [1:0] len, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_reg = code; req_len = len; req_data = data;
    while (!req_ready) @(negedge clk);
    expect_frame(code, len, data);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_val.size() != 0 || !req_ready || !cs_n) @(negedge clk);
  endtask

  // Monitor: samples away from the active edge
  logic psclk = 1'b1, pcs = 1'b1, pdone = 1'b0, fall_sdo = 1'b0;
  int lo_n = 0, hi_n = 0, gap = 0, nbits = 0;
  logic [26:0] got = '0;

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (done && pdone) check(0, "R10 done wider than one cycle", 1, 0);
      if (!cs_n && req_ready) check(0, "R9 ready during frame", 1, 0);
      if (!cs_n) begin
        if (pcs) begin
          if (frames_seen > 0) check(gap >= DIV, "R8 gap between frames", gap, DIV);
          nbits = 0; got = '0; hi_n = 0; lo_n = 0;
        end
        if (!sclk && psclk) begin
          check(hi_n == HALF, "R7 high or lead phase length", hi_n, HALF);
          fall_sdo = sdo; lo_n = 0;
        end
        if (sclk && !psclk) begin
          check(lo_n == HALF, "R7 low phase length", lo_n, HALF);
          check(sdo == fall_sdo, "R7 sdo stable across rise", sdo, fall_sdo);
          got = {got[25:0], sdo}; nbits++; hi_n = 0;
        end
        if (sclk) hi_n++; else lo_n++;
      end else begin
        if (!pcs) begin
          check(done == 1'b1, "R10 done at cs rise", done, 1);
          if (exp_val.size() == 0) check(0, "R9 unexpected frame", got, 0);
          else begin
            logic [26:0] ev;
            int en;
            ev = exp_val.pop_front();
            en = exp_len.pop_front();
            check(nbits == en, "R3/R4/R5/R6 frame bit count", nbits, en);
            check(got == ev, "R2 frame contents", got, ev);
          end
          frames_seen++;
          gap = 0;
        end
        gap++;
        if (!sclk) check(0, "R7 sclk low while idle", 0, 1);
        if (done && pcs) check(0, "R10 done without frame end", 1, 0);
      end
      psclk = sclk; pcs = cs_n; pdone = done;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
    check(sclk == 1'b1, "R1 sclk after reset", sclk, 1);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(done == 1'b0, "R1 done after reset", done, 0);
    mon_on = 1;

    send(8'h29, 2'd0, 16'h0000);   // R3 command only
    wait_idle();
    send(8'hB1, 2'd1, 16'h0056);   // R4 byte write
    wait_idle();
    send(8'hC3, 2'd2, 16'h2040);   // R5 half-word, high byte first
    wait_idle();
    send(8'h11, 2'd3, 16'hFFFF);   // R6 reserved length acts as command only
    wait_idle();
    send(8'hA5, 2'd1, 16'hA5C3);   // R4 only the low byte is sent
    wait_idle();

    // R8 back-to-back frames keep the minimum gap
    send(8'hB8, 2'd2, 16'hFFF9);
    send(8'h28, 2'd0, 16'h0000);
    send(8'hFF, 2'd2, 16'h0180);
    wait_idle();

    // R9 fields changed after acceptance, with valid raised while busy, have no effect
    send(8'h3A, 2'd1, 16'h0060);
    @(negedge clk);
    req_valid = 1'b1; req_reg = 8'h00; req_len = 2'd2; req_data = 16'hDEAD;
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    req_reg = 8'h77; req_data = 16'h1234;
    wait_idle();
    repeat (3 * DIV) @(negedge clk);
    check(frames_seen == 9, "R9 frame count", frames_seen, 9);
    check(exp_val.size() == 0, "R9 all frames observed", exp_val.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule